// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block sits on the inbound path of a PCI host bridge and turns bus addresses into host physical addresses. Software programs four windows. Each window has a base register that holds an enable flag and a scatter-gather flag, a size mask and a translated-base register. A bus address that falls in a direct window is translated by subtracting the window base. A bus address that falls in a scatter-gather window is translated by fetching a page-table entry through a memory read port. The page table starts at the translated-base address. Page-table entries with the valid bit set are kept in a small fully associative translation cache, so a later access to the same page needs no table read.

Requests use a valid/ready handshake. Every accepted request produces exactly one response pulse. The response carries a physical address, a fault flag for an invalid table entry, or a miss flag when no enabled window claims the address. Writing the invalidate register empties the cache. Software does this before and after it reprograms the windows. A walk that is in flight when the invalidate arrives still delivers its response, but its entry is discarded and not cached.

Top module: `dmawin_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `pt_req` are 0, and every configuration register reads 0.
- R2: The configuration map is as follows. Addresses 0-3 are the window bases: bit 0 is enable, bit 1 is scatter-gather, and bits [ADDR_W-1:PAGE_SHIFT] are the base address. Addresses 4-7 are the masks, which keep only bits [ADDR_W-1:PAGE_SHIFT]. Addresses 8-11 are the translated bases, stored whole. Address 12 is invalidate-all and always reads 0. Every other bit reads back as 0. A window whose base is written as zero claims no address.
- R3: Window i covers base through base + (mask | 2^PAGE_SHIFT-1), both ends included. An address that no enabled window covers gives a response with `rsp_miss`=1, `rsp_fault`=0 and `rsp_addr`=0.
- R4: When several enabled windows cover an address, the lowest-numbered window translates it.
- R5: In a direct window (scatter-gather flag 0), `rsp_addr` is the bus address minus the window base. The response is valid in the cycle after the request is accepted.
- R6: A scatter-gather cache miss raises `pt_req` for one cycle, in the cycle after acceptance. `pt_addr` = translated base + index*(ADDR_W/8), where index = (bus address - base) >> PAGE_SHIFT. The response is valid in the cycle after `pt_valid`.
- R7: For a table entry with bit 0 set, `rsp_addr` = ((entry >> 1) << PAGE_SHIFT) + (bus address mod 2^PAGE_SHIFT).
- R8: For a table entry with bit 0 clear, the response has `rsp_fault`=1 and `rsp_addr`=0. The entry is not cached, so the next access to that page reads the table again.
- R9: A scatter-gather access whose window and page are cached makes no table read. Its response comes in the cycle after acceptance. Cache tags include the window number.
- R10: The cache holds TLB_DEPTH entries. Each walk that installs an entry writes it into the next slot in round-robin order.
- R11: Any write to the invalidate register empties the cache. The next access to every scatter-gather page makes a table read.
- R12: An invalidate that arrives while a walk is in flight still lets that walk respond normally, but its entry is not installed.
- R13: `req_ready` is 0 from the cycle after a walking request is accepted until its table data returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address, used for both read and write |
| cfg_wdata | input | ADDR_W | Configuration write data |
| cfg_rdata | output | ADDR_W | Combinational read data for `cfg_addr` |
| req_valid | input | 1 | Translation request valid |
| req_addr | input | ADDR_W | Bus address to translate |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_addr | output | ADDR_W | Physical address (0 on miss or fault) |
| rsp_fault | output | 1 | Table entry was invalid |
| rsp_miss | output | 1 | No enabled window covers the address |
| pt_req | output | 1 | Page-table read strobe |
| pt_addr | output | ADDR_W | Page-table entry byte address |
| pt_valid | input | 1 | Page-table read data valid |
| pt_data | input | ADDR_W | Page-table entry |

## Verification
The bench builds the block with ADDR_W=32 and PAGE_SHIFT=13, as the defaults set. It overrides TLB_DEPTH to 4 instead of 8. With only four slots, a handful of distinct pages is enough to wrap the round-robin pointer. That makes eviction of a still-wanted page reachable and lets the bench observe it as a fresh table read. The table memory in the bench answers three cycles after each read. This leaves a window in which an invalidate lands in the middle of a walk and `req_ready` can be seen held low.

// File: rtl/dmawin_pkg.sv
package dmawin_pkg;
  localparam int NWIN  = 4;
  localparam int WIN_W = 2;
  // configuration address of the invalidate-all register
  localparam logic [3:0] CFG_FLUSH_ADDR = 4'd12;

  typedef enum logic {ST_IDLE, ST_WALK} walk_st_e;
endpackage

// File: rtl/dmawin_regs.sv
module dmawin_regs
  import dmawin_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 13
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [3:0]                   cfg_addr,
  input  logic [ADDR_W-1:0]            cfg_wdata,
  output logic [ADDR_W-1:0]            cfg_rdata,
  output logic [NWIN-1:0][ADDR_W-1:0]  base_q,
  output logic [NWIN-1:0][ADDR_W-1:0]  mask_q,
  output logic [NWIN-1:0][ADDR_W-1:0]  tbase_q,
  output logic                         flush_o
);
  localparam logic [ADDR_W-1:0] FIELD = ~((ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] FLAGS = ADDR_W'(3);

  assign flush_o = cfg_we && (cfg_addr == CFG_FLUSH_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      mask_q  <= '0;
      tbase_q <= '0;
    end else if (cfg_we) begin
      unique case (cfg_addr[3:2])
        2'd0:    base_q[cfg_addr[1:0]]  <= cfg_wdata & (FIELD | FLAGS);
        2'd1:    mask_q[cfg_addr[1:0]]  <= cfg_wdata & FIELD;
        2'd2:    tbase_q[cfg_addr[1:0]] <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (cfg_addr[3:2])
      2'd0:    cfg_rdata = base_q[cfg_addr[1:0]];
      2'd1:    cfg_rdata = mask_q[cfg_addr[1:0]];
      2'd2:    cfg_rdata = tbase_q[cfg_addr[1:0]];
      default: cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dmawin_match.sv
module dmawin_match
  import dmawin_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 13
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [NWIN-1:0][ADDR_W-1:0]  base_i,
  input  logic [NWIN-1:0][ADDR_W-1:0]  mask_i,
  output logic                         hit_o,
  output logic [WIN_W-1:0]             win_o,
  output logic                         sg_o,
  output logic [ADDR_W-1:0]            off_o
);
  localparam logic [ADDR_W-1:0] LOW   = (ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] FIELD = ~LOW;

  logic [NWIN-1:0]             hit_vec;
  logic [NWIN-1:0]             grant;
  logic [NWIN-1:0][ADDR_W-1:0] off_vec;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    logic [ADDR_W-1:0] b, m;
    assign b          = base_i[g] & FIELD;
    assign m          = mask_i[g] | LOW;
    assign off_vec[g] = addr_i - b;
    assign hit_vec[g] = base_i[g][0] && (addr_i >= b) && (off_vec[g] <= m);
  end

  // lowest-numbered covering window wins
  always_comb begin
    grant = '0;
    win_o = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        grant = '0;
        grant[i] = 1'b1;
        win_o = WIN_W'(i);
      end
    end
  end

  assign hit_o = |hit_vec;
  assign sg_o  = base_i[win_o][1];
  assign off_o = off_vec[win_o];

  assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((|grant) == hit_o));
endmodule

// File: rtl/dmawin_tlb.sv
module dmawin_tlb
  import dmawin_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 13,
  parameter int DEPTH      = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush_i,
  input  logic [WIN_W-1:0]         lk_win,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] lk_idx,
  output logic                     lk_hit,
  output logic [ADDR_W-1:0]        lk_pte,
  input  logic                     ins_i,
  input  logic [WIN_W-1:0]         ins_win,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] ins_idx,
  input  logic [ADDR_W-1:0]        ins_pte
);
  localparam int IDXW = ADDR_W - PAGE_SHIFT;
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  vld_q;
  logic [WIN_W-1:0]  win_q [DEPTH];
  logic [IDXW-1:0]   idx_q [DEPTH];
  logic [ADDR_W-1:0] pte_q [DEPTH];
  logic [PTRW-1:0]   rr_q;
  logic [DEPTH-1:0]  hit_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign hit_vec[g] = vld_q[g] && (win_q[g] == lk_win) && (idx_q[g] == lk_idx);
  end

  always_comb begin
    lk_pte = '0;
    for (int i = 0; i < DEPTH; i++)
      if (hit_vec[i]) lk_pte = lk_pte | pte_q[i];
  end
  assign lk_hit = |hit_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        win_q[i] <= '0;
        idx_q[i] <= '0;
        pte_q[i] <= '0;
      end
    end else if (flush_i) begin
      vld_q <= '0;
    end else if (ins_i) begin
      vld_q[rr_q] <= 1'b1;
      win_q[rr_q] <= ins_win;
      idx_q[rr_q] <= ins_idx;
      pte_q[rr_q] <= ins_pte;
      rr_q        <= (rr_q == PTRW'(DEPTH - 1)) ? '0 : rr_q + PTRW'(1);
    end
  end

  assert_tag_unique_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !lk_hit);
endmodule

// File: rtl/dmawin_xlate.sv
module dmawin_xlate
  import dmawin_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 13,
  parameter int TLB_DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_fault,
  output logic              rsp_miss,
  output logic              pt_req,
  output logic [ADDR_W-1:0] pt_addr,
  input  logic              pt_valid,
  input  logic [ADDR_W-1:0] pt_data
);
  localparam int IDXW   = ADDR_W - PAGE_SHIFT;
  localparam int PTE_SH = $clog2(ADDR_W / 8);

  function automatic logic [ADDR_W-1:0] sg_phys(input logic [ADDR_W-1:0] pte,
                                                input logic [PAGE_SHIFT-1:0] pg);
    return ((pte >> 1) << PAGE_SHIFT) | ADDR_W'(pg);
  endfunction

  function automatic logic [ADDR_W-1:0] pte_addr(input logic [ADDR_W-1:0] tb,
                                                 input logic [IDXW-1:0] idx);
    return tb + (ADDR_W'(idx) << PTE_SH);
  endfunction

  logic [NWIN-1:0][ADDR_W-1:0] base_q, mask_q, tbase_q;
  logic              flush;
  logic              m_hit, m_sg;
  logic [WIN_W-1:0]  m_win;
  logic [ADDR_W-1:0] m_off;
  logic [IDXW-1:0]   lk_idx;
  logic              tlb_hit;
  logic [ADDR_W-1:0] tlb_pte;
  logic              install;

  walk_st_e             state;
  logic [WIN_W-1:0]     w_win;
  logic [IDXW-1:0]      w_idx;
  logic [PAGE_SHIFT-1:0] w_pg;
  logic                 kill;

  dmawin_regs #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_regs (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .base_q, .mask_q, .tbase_q, .flush_o(flush));

  dmawin_match #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_match (
    .clk, .rst_n, .addr_i(req_addr), .base_i(base_q), .mask_i(mask_q),
    .hit_o(m_hit), .win_o(m_win), .sg_o(m_sg), .off_o(m_off));

  assign lk_idx  = IDXW'(m_off >> PAGE_SHIFT);
  assign install = (state == ST_WALK) && pt_valid && pt_data[0] && !kill && !flush;

  dmawin_tlb #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .DEPTH(TLB_DEPTH)) u_tlb (
    .clk, .rst_n, .flush_i(flush),
    .lk_win(m_win), .lk_idx(lk_idx), .lk_hit(tlb_hit), .lk_pte(tlb_pte),
    .ins_i(install), .ins_win(w_win), .ins_idx(w_idx), .ins_pte(pt_data));

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_fault <= 1'b0;
      rsp_miss  <= 1'b0;
      pt_req    <= 1'b0;
      pt_addr   <= '0;
      w_win     <= '0;
      w_idx     <= '0;
      w_pg      <= '0;
      kill      <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      pt_req    <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          if (!m_hit) begin
            rsp_valid <= 1'b1; rsp_miss <= 1'b1; rsp_fault <= 1'b0; rsp_addr <= '0;
          end else if (!m_sg) begin
            rsp_valid <= 1'b1; rsp_miss <= 1'b0; rsp_fault <= 1'b0; rsp_addr <= m_off;
          end else if (tlb_hit) begin
            rsp_valid <= 1'b1; rsp_miss <= 1'b0; rsp_fault <= 1'b0;
            rsp_addr  <= sg_phys(tlb_pte, req_addr[PAGE_SHIFT-1:0]);
          end else begin
            state   <= ST_WALK;
            pt_req  <= 1'b1;
            pt_addr <= pte_addr(tbase_q[m_win], lk_idx);
            w_win   <= m_win;
            w_idx   <= lk_idx;
            w_pg    <= req_addr[PAGE_SHIFT-1:0];
            kill    <= 1'b0;
          end
        end
        ST_WALK: begin
          if (flush) kill <= 1'b1;
          if (pt_valid) begin
            state     <= ST_IDLE;
            rsp_valid <= 1'b1;
            rsp_miss  <= 1'b0;
            rsp_fault <= !pt_data[0];
            rsp_addr  <= pt_data[0] ? sg_phys(pt_data, w_pg) : '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_rsp_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(req_valid && req_ready) || $past(pt_valid)));
  assert_miss_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (rsp_addr == '0 && !rsp_fault));
  assert_fault_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_addr == '0));
  // R13: the walk holds the request side off after its single read strobe
  assert_single_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pt_req |=> (!pt_req && !req_ready));
endmodule

// File: tb/dmawin_xlate_tb.sv
module dmawin_xlate_tb_top;
  localparam int AW  = 32;
  localparam int PS  = 13;
  localparam int TLB = 4;
  localparam int LAT = 3;
  localparam logic [31:0] FIELD = ~((32'd1 << PS) - 32'd1);
  localparam logic [31:0] LOWB  = (32'd1 << PS) - 32'd1;

  logic clk, rst_n;
  logic cfg_we;
  logic [3:0] cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic req_valid, req_ready, rsp_valid, rsp_fault, rsp_miss;
  logic [31:0] req_addr, rsp_addr;
  logic pt_req, pt_valid;
  logic [31:0] pt_addr, pt_data;

  int errors = 0;
  int checks = 0;
  int nreads = 0;
  bit rsp_window = 0;

  logic [31:0] wb [4];
  logic [31:0] wm [4];
  logic [31:0] wt [4];
  int mc_v [TLB];
  int mc_w [TLB];
  int mc_i [TLB];
  int mc_rr = 0;
  logic [31:0] ptm [int unsigned];

  dmawin_xlate #(.ADDR_W(AW), .PAGE_SHIFT(PS), .TLB_DEPTH(TLB)) dut_i (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .req_valid, .req_addr, .req_ready, .rsp_valid, .rsp_addr, .rsp_fault, .rsp_miss,
    .pt_req, .pt_addr, .pt_valid, .pt_data);

  initial begin
    clk = 0;
    forever #10 clk = ~clk;
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    if (ptm.exists(a)) return ptm[a];
    return 32'h0;
  endfunction

  // page-table memory with fixed latency
  initial begin
    pt_valid = 0;
    pt_data  = 0;
    forever begin
      @(negedge clk);
      pt_valid = 0;
      if (rst_n && pt_req) begin
        logic [31:0] a;
        a = pt_addr;
        nreads++;
        repeat (LAT - 1) @(negedge clk);
        pt_data  = mem_rd(a);
        pt_valid = 1;
      end
    end
  end

  // every-clock guard: no response outside an outstanding request
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (rsp_valid && !rsp_window) begin
        errors++;
        $display("FAIL R5: actual=0x1 expected=0x0 (unrequested response)");
      end
    end
  end

  function automatic int find_win(input logic [31:0] a);
    for (int i = 0; i < 4; i++) begin
      longint unsigned lo, hi;
      lo = longint'(wb[i] & FIELD);
      hi = lo + longint'(wm[i] | LOWB);
      if (wb[i][0] && longint'(a) >= lo && longint'(a) <= hi) return i;
    end
    return -1;
  endfunction

  function automatic bit cache_has(input int w, input int idx);
    for (int i = 0; i < TLB; i++)
      if (mc_v[i] != 0 && mc_w[i] == w && mc_i[i] == idx) return 1;
    return 0;
  endfunction

  task automatic model_flush();
    for (int i = 0; i < TLB; i++) mc_v[i] = 0;
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    if (a < 4)       wb[a]    = d & (FIELD | 32'd3);
    else if (a < 8)  wm[a-4]  = d & FIELD;
    else if (a < 12) wt[a-8]  = d;
    else if (a == 12) model_flush();
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cfg_check(input logic [3:0] a, input logic [31:0] exp, input string rq);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(cfg_rdata == exp, rq, cfg_rdata, exp);
  endtask

  task automatic do_req(input logic [31:0] a, input bit fmid, input string rq);
    int w, idx, r0, cyc, lat;
    longint unsigned off;
    bit walk, e_miss, e_fault;
    logic [31:0] e_addr, e_pta, pte;
    w = find_win(a);
    e_miss = (w < 0); walk = 0; e_fault = 0; e_addr = 0; e_pta = 0; pte = 0; idx = 0;
    if (!e_miss) begin
      off = longint'(a) - longint'(wb[w] & FIELD);
      if (!wb[w][1]) e_addr = off[31:0];
      else begin
        idx   = int'(off / (64'd1 << PS));
        walk  = !cache_has(w, idx);
        e_pta = wt[w] + 32'(idx * 4);
        pte   = mem_rd(e_pta);
        if (pte[0]) e_addr = 32'((longint'(pte) / 2) * (64'd1 << PS) + (a % (32'd1 << PS)));
        else e_fault = 1;
      end
    end
    r0 = nreads;
    @(negedge clk);
    chk(req_ready == 1, "R13", req_ready, 1);
    req_valid = 1; req_addr = a; rsp_window = 1;
    @(negedge clk);
    req_valid = 0;
    if (walk) begin
      chk(pt_req == 1 && pt_addr == e_pta, "R6", pt_addr, e_pta);
      chk(req_ready == 0, "R13", req_ready, 0);
    end
    if (fmid) begin cfg_we = 1; cfg_addr = 4'd12; cfg_wdata = 0; end
    cyc = 0;
    while (!rsp_valid && cyc < 40) begin
      @(negedge clk);
      cfg_we = 0;
      cyc++;
    end
    cfg_we = 0;
    lat = walk ? LAT : 0;
    chk(cyc == lat, walk ? "R6" : (e_miss ? "R3" : "R9"), cyc, lat);
    chk(rsp_miss == e_miss, "R3", rsp_miss, e_miss);
    chk(rsp_fault == e_fault, "R8", rsp_fault, e_fault);
    chk(rsp_addr == e_addr, rq, rsp_addr, e_addr);
    chk(nreads - r0 == (walk ? 1 : 0), "R9", nreads - r0, walk ? 1 : 0);
    if (fmid) model_flush();
    if (walk && pte[0] && !fmid) begin
      mc_v[mc_rr] = 1; mc_w[mc_rr] = w; mc_i[mc_rr] = idx;
      mc_rr = (mc_rr + 1) % TLB;
    end
    @(negedge clk);
    rsp_window = 0;
  endtask

  function automatic logic [31:0] w0_page(input int k, input int o);
    return 32'h0080_0000 + 32'(k * (1 << PS)) + 32'(o);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; req_valid = 0; req_addr = 0;
    for (int i = 0; i < 4; i++) begin wb[i] = 0; wm[i] = 0; wt[i] = 0; end
    model_flush();
    for (int k = 0; k < 16; k++)
      ptm[32'h1000_0000 + 32'(4 * k)] = (k == 2) ? 32'h0000_0100 : (((32'h100 + 32'(k)) << 1) | 32'd1);
    ptm[32'h2000_0000] = (32'h7FFFF << 1) | 32'd1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1, "R1", req_ready, 1);
    chk(rsp_valid == 0 && pt_req == 0, "R1", {rsp_valid, pt_req}, 0);
    for (int a = 0; a < 13; a++) cfg_check(4'(a), 32'h0, "R1");

    // R2 field masking, readback and disable-by-zero
    cfg_write(4'd3, 32'h1234_5677);
    cfg_write(4'd7, 32'h00FF_FFFF);
    cfg_write(4'd11, 32'hDEAD_BEEF);
    cfg_check(4'd3, 32'h1234_4003, "R2");
    cfg_check(4'd7, 32'h00FF_E000, "R2");
    cfg_check(4'd11, 32'hDEAD_BEEF, "R2");
    cfg_write(4'd3, 32'h0);
    cfg_write(4'd11, 32'h0);
    do_req(32'h1234_4000, 0, "R2");

    // program windows
    cfg_write(4'd0, 32'h0080_0003); cfg_write(4'd4, 32'h007F_FFFF); cfg_write(4'd8, 32'h1000_0000);
    cfg_write(4'd1, 32'h8000_0001); cfg_write(4'd5, 32'h3FFF_FFFF); cfg_write(4'd9, 32'h0);
    cfg_write(4'd2, 32'hC000_0003); cfg_write(4'd6, 32'h3FFF_FFFF); cfg_write(4'd10, 32'h2000_0000);
    cfg_write(4'd12, 32'h0);
    cfg_check(4'd12, 32'h0, "R2");

    do_req(32'h0000_1000, 0, "R3");
    do_req(32'h007F_FFFF, 0, "R3");
    do_req(32'h8000_1234, 0, "R5");
    do_req(32'h8000_0000, 0, "R5");
    do_req(32'hBFFF_FFFF, 0, "R3");
    // SG path, window number in tag
    do_req(w0_page(0, 8), 0, "R7");
    do_req(32'hC000_0008, 0, "R7");
    do_req(w0_page(0, 12), 0, "R9");
    do_req(32'hC000_1FFC, 0, "R9");
    do_req(w0_page(1, 16), 0, "R7");
    do_req(w0_page(1, 32), 0, "R9");
    // invalid entry faults and is re-read
    do_req(w0_page(2, 0), 0, "R8");
    do_req(w0_page(2, 4), 0, "R8");
    // round-robin eviction
    for (int k = 3; k < 8; k++) do_req(w0_page(k, 0), 0, "R10");
    do_req(w0_page(0, 0), 0, "R10");
    do_req(w0_page(6, 4), 0, "R10");
    do_req(w0_page(7, 4), 0, "R10");
    // invalidate-all
    cfg_write(4'd12, 32'h5A5A_5A5A);
    cfg_check(4'd12, 32'h0, "R11");
    do_req(w0_page(7, 8), 0, "R11");
    // invalidate during walk
    do_req(w0_page(9, 0), 1, "R12");
    do_req(w0_page(9, 4), 0, "R12");
    do_req(w0_page(9, 8), 0, "R9");
    // priority between overlapping windows
    cfg_write(4'd3, 32'h9000_0001); cfg_write(4'd7, 32'h0FFF_FFFF);
    do_req(32'h9000_0100, 0, "R4");
    cfg_write(4'd1, 32'h0);
    do_req(32'h9000_0100, 0, "R4");
    do_req(32'h8000_0100, 0, "R2");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule